// File: doc/BRIEF.md
# Triple-Copy Delay Timer with Divergence Flag

This block supplies the delay timing of a safety controller from three identical down-counters that run in lockstep off the controller's 1 ms clock. A start pulse loads all copies with the same terminal count. Each copy then counts down once per clock and raises its own expiry bit when it reaches zero. The three expiry bits go straight to the controller's next-state logic, which interprets them together.

The copies are not voted. A comparator watches every pair of copies, checking both the count values and the expiry bits. It latches a divergence flag the first time any pair differs. The controller uses that flag to switch off its critical output and stay in lockout. Only a reset clears the flag. A fault in one timer copy therefore shows up within one clock cycle, which is far inside the three-second limit on any dangerous activation.

Top module: `trip_delay_timer`

## Requirements
- R1: While reset is held and on the first cycle after it, all expiry bits are 0 and the divergence flag is 0. Reset is synchronous and active high.
- R2: A start pulse with a nonzero terminal count clears every expiry bit at the clock edge that samples it.
- R3: With no further start, every expiry bit goes to 1 exactly T clock edges after the start edge, where T is the loaded terminal count (1 to 4095). All copies rise on the same edge, each when its count reaches 0.
- R4: A terminal count of 0 makes every expiry bit 1 at the start edge itself.
- R5: Once set, an expiry bit stays 1 until the next start pulse.
- R6: A start pulse while counting reloads all copies with the new terminal count at the same edge. Expiry then follows R3, counted from the latest start.
- R7: A start pulse while already expired clears the expiry bits and begins a new count.
- R8: While all copies agree in count and expiry bit, the divergence flag stays 0.
- R9: When any pair of copies differs in count value or in expiry bit, the divergence flag is 1 after the next clock edge.
- R10: The divergence flag stays 1 through any later start pulses or agreement, until reset.
- R11: Reset clears the divergence flag, and the timers work normally afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock, one tick per millisecond |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; loads all copies with the terminal count |
| term_cnt_i | input | CNT_W (12) | Terminal count in ticks |
| expired_o | output | COPIES (3) | Expiry bit of each timer copy |
| mismatch_o | output | 1 | Sticky flag: some pair of copies diverged |

## Verification
The bound assertions check the following on every cycle:
- any divergence between copies is flagged on the next edge;
- the flag is sticky;
- a start loads every copy with the same count;
- expiry bits hold until a start;
- a copy expires only at a zero count.

The exact delay from start to expiry needs the bench's scenarios to show it, including the zero count, the full 4095 count, a reload during counting and a restart after expiry. So does the flag rising after one copy is corrupted and being cleared by reset.

// File: rtl/tdt_pkg.sv
package tdt_pkg;

  // Phase of a single timer copy
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_RUN  = 2'b01,
    PH_DONE = 2'b10
  } phase_e;

  localparam int unsigned CNT_W_DEF  = 12;
  localparam int unsigned COPIES_DEF = 3;

endpackage

// File: rtl/tdt_copy.sv
module tdt_copy
  import tdt_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired_o
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  phase_e           phase_q, phase_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n   = cnt_q;
    phase_n = phase_q;
    if (start_i) begin
      cnt_n   = load_i;
      phase_n = (load_i == ZERO) ? PH_DONE : PH_RUN;
    end else begin
      case (phase_q)
        PH_RUN: begin
          if (cnt_q == ZERO) begin
            // count already spent: finish without wrapping
            phase_n = PH_DONE;
          end else begin
            cnt_n = cnt_q - ONE;
            if (cnt_q == ONE) phase_n = PH_DONE;
          end
        end
        PH_IDLE, PH_DONE: begin
          phase_n = phase_q;
        end
        default: begin
          // illegal encoding: drop to idle, the sister copies expose it
          phase_n = PH_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= ZERO;
      phase_q <= PH_IDLE;
    end else begin
      cnt_q   <= cnt_n;
      phase_q <= phase_n;
    end
  end

  assign cnt_o     = cnt_q;
  assign expired_o = (phase_q == PH_DONE);

endmodule

// File: rtl/tdt_disagree.sv
module tdt_disagree #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned COPIES = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [COPIES-1:0][CNT_W-1:0] cnt_i,
  input  logic [COPIES-1:0]            exp_i,
  output logic                         flag_o
);

  // pair_diff[a][b] set when copies a and b (a < b) differ
  logic [COPIES-1:0][COPIES-1:0] pair_diff;
  logic                          any_diff;
  logic                          flag_q;

  for (genvar a = 0; a < COPIES; a++) begin : g_row
    for (genvar b = 0; b < COPIES; b++) begin : g_col
      if (b > a) begin : g_pair
        assign pair_diff[a][b] = (cnt_i[a] != cnt_i[b]) || (exp_i[a] != exp_i[b]);
      end else begin : g_none
        assign pair_diff[a][b] = 1'b0;
      end
    end
  end

  assign any_diff = |pair_diff;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_q | any_diff;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/trip_delay_timer.sv
module trip_delay_timer
  import tdt_pkg::*;
#(
  parameter int unsigned CNT_W  = CNT_W_DEF,
  parameter int unsigned COPIES = COPIES_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  term_cnt_i,
  output logic [COPIES-1:0] expired_o,
  output logic              mismatch_o
);

  logic [COPIES-1:0][CNT_W-1:0] cnt_all;

  for (genvar i = 0; i < COPIES; i++) begin : g_copy
    tdt_copy #(
      .CNT_W(CNT_W)
    ) u_copy (
      .clk      (clk),
      .rst      (rst),
      .start_i  (start_i),
      .load_i   (term_cnt_i),
      .cnt_o    (cnt_all[i]),
      .expired_o(expired_o[i])
    );
  end

  tdt_disagree #(
    .CNT_W (CNT_W),
    .COPIES(COPIES)
  ) u_disagree (
    .clk   (clk),
    .rst   (rst),
    .cnt_i (cnt_all),
    .exp_i (expired_o),
    .flag_o(mismatch_o)
  );

endmodule

// File: rtl/tdt_checker.sv
module tdt_checker #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned COPIES = 3
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         start_i,
  input logic [CNT_W-1:0]             term_cnt_i,
  input logic [COPIES-1:0]            expired_o,
  input logic                         mismatch_o,
  input logic [COPIES-1:0][CNT_W-1:0] cnt_all
);

  logic agree;
  always_comb begin
    agree = 1'b1;
    for (int i = 1; i < COPIES; i++) begin
      if (cnt_all[i] != cnt_all[0] || expired_o[i] != expired_o[0]) agree = 1'b0;
    end
  end

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (expired_o == '0 && !mismatch_o))
    else $error("R1 outputs not clear after reset");

  // R2
  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    (start_i && term_cnt_i != '0) |=> (expired_o == '0))
    else $error("R2 expiry not cleared by start");

  // R4
  a_r4_zero_term: assert property (@(posedge clk) disable iff (rst)
    (start_i && term_cnt_i == '0) |=> (&expired_o))
    else $error("R4 zero count did not expire at start");

  // R5
  a_r5_expiry_holds: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> ((expired_o & $past(expired_o)) == $past(expired_o)))
    else $error("R5 expiry dropped without start");

  for (genvar i = 0; i < COPIES; i++) begin : g_per_copy
    // R3
    a_r3_expire_at_zero: assert property (@(posedge clk) disable iff (rst)
      $rose(expired_o[i]) |-> (cnt_all[i] == '0))
      else $error("R3 copy expired with nonzero count");
    // R6
    a_r6_start_loads_all: assert property (@(posedge clk) disable iff (rst)
      start_i |=> (cnt_all[i] == $past(term_cnt_i)))
      else $error("R6 copy not loaded by start");
  end

  // R8
  a_r8_agree_no_flag: assert property (@(posedge clk) disable iff (rst)
    (agree && !mismatch_o) |=> !mismatch_o)
    else $error("R8 flag raised while copies agree");

  // R9
  a_r9_split_flags: assert property (@(posedge clk) disable iff (rst)
    !agree |=> mismatch_o)
    else $error("R9 divergence not flagged");

  // R10
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    mismatch_o |=> mismatch_o)
    else $error("R10 flag cleared without reset");

endmodule

bind trip_delay_timer tdt_checker #(
  .CNT_W (CNT_W),
  .COPIES(COPIES)
) u_tdt_checker (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .term_cnt_i(term_cnt_i),
  .expired_o (expired_o),
  .mismatch_o(mismatch_o),
  .cnt_all   (cnt_all)
);

// File: tb/test_trip_delay_timer.sv
module test_trip_delay_timer;

  localparam int CLK_PERIOD   = 10;
  localparam int CNT_W        = 12;
  localparam int COPIES       = 3;
  localparam int WATCHDOG_CYC = 150000;
  localparam int SEED         = 20240611;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  term = '0;
  logic [COPIES-1:0] expired;
  logic              mismatch;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model state
  logic [CNT_W-1:0] m_cnt;
  logic             m_run, m_exp, m_mis;
  bit               m_fault = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trip_delay_timer #(
    .CNT_W (CNT_W),
    .COPIES(COPIES)
  ) i_trip_delay_timer (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .term_cnt_i(term),
    .expired_o (expired),
    .mismatch_o(mismatch)
  );

  // model from the requirements: expiry T edges after start, sticky flag
  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= '0; m_run <= 1'b0; m_exp <= 1'b0; m_mis <= 1'b0;
    end else begin
      m_mis <= m_mis | m_fault;
      if (start) begin
        m_cnt <= term;
        m_run <= (term != '0);
        m_exp <= (term == '0);
      end else if (m_run) begin
        m_cnt <= m_cnt - 1'b1;
        if (m_cnt == CNT_W'(1)) begin
          m_run <= 1'b0;
          m_exp <= 1'b1;
        end
      end
    end
  end

  function automatic logic [COPIES-1:0] exp_bits();
    return m_exp ? '1 : '0;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic compare(input string tag);
    if (!m_fault) chk(tag, "expiry bits", 32'(expired), 32'(exp_bits()));
    chk(tag, "divergence flag", 32'(mismatch), 32'(m_mis));
  endtask

  task automatic step(input bit s, input logic [CNT_W-1:0] t, input string tag);
    start = s;
    term  = t;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    compare(tag);
  endtask

  // start with t, then count extra edges until all copies expire
  task automatic count_to_expiry(input logic [CNT_W-1:0] t, input string tag);
    int n = 0;
    step(1'b1, t, tag);
    while (expired !== '1 && n < 5000) begin
      step(1'b0, '0, tag);
      n++;
    end
    chk(tag, "edges to expiry", 32'(n), 32'(t));
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(SEED));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: held in reset
    chk("R1", "expiry in reset", 32'(expired), 32'h0);
    chk("R1", "flag in reset", 32'(mismatch), 32'h0);
    rst = 1'b0;
    step(1'b0, '0, "R1");

    // R3: short count
    count_to_expiry(CNT_W'(5), "R3");
    // R5: hold without start
    repeat (8) step(1'b0, CNT_W'(9), "R5");
    chk("R5", "expiry held", 32'(expired), 32'h7);

    // R4: zero count
    count_to_expiry('0, "R4");

    // R2 then R6: reload while counting
    step(1'b1, CNT_W'(8), "R2");
    chk("R2", "expiry cleared", 32'(expired), 32'h0);
    repeat (3) step(1'b0, '0, "R6");
    count_to_expiry(CNT_W'(4), "R6");

    // R7: restart from expired
    count_to_expiry(CNT_W'(6), "R7");

    // R3: full-range count
    count_to_expiry('1, "R3");

    // R8: random traffic, flag must stay low
    for (int k = 0; k < 2500; k++) begin
      bit s = (($urandom % 6) == 0);
      logic [CNT_W-1:0] t = CNT_W'($urandom % 24);
      step(s, t, "R8");
    end
    chk("R8", "flag after random run", 32'(mismatch), 32'h0);

    // R9: corrupt one copy while counting
    step(1'b1, CNT_W'(60), "R9");
    repeat (4) step(1'b0, '0, "R9");
    force i_trip_delay_timer.g_copy[1].u_copy.cnt_q = CNT_W'(3);
    m_fault = 1'b1;
    step(1'b0, '0, "R9");
    release i_trip_delay_timer.g_copy[1].u_copy.cnt_q;
    chk("R9", "flag after divergence", 32'(mismatch), 32'h1);

    // R10: sticky through starts
    step(1'b1, CNT_W'(10), "R10");
    step(1'b1, '0, "R10");
    repeat (5) step(1'b0, '0, "R10");
    chk("R10", "flag still set", 32'(mismatch), 32'h1);

    // R11: reset clears the flag
    rst = 1'b1;
    @(posedge clk);
    m_fault = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R11", "flag after reset", 32'(mismatch), 32'h0);
    chk("R11", "expiry after reset", 32'(expired), 32'h0);
    rst = 1'b0;
    count_to_expiry(CNT_W'(7), "R11");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule